// File: doc/BRIEF.md
# Grouped 16-bit Execution ALU

This block is the integer execution unit of a small processor core. Each cycle it takes two 16-bit operands and a 5-bit function code. It returns a 16-bit result with a carry flag and a zero flag, and all three are registered once, so they appear one clock after the inputs are presented.

The function code is a square map. The upper two bits pick one of four groups and the lower three bits pick one of eight operations inside that group:

- group 0 is bitwise logic;
- group 1 is add, subtract and signed compare;
- group 2 is shifts and rotates, plus single-cycle helpers for an 8x8 multiply;
- group 3 moves a register and extracts or merges its low byte.

The core around the block supplies the operands and writes back the result. Register access, fetch and memory are handled elsewhere.

Top module: `alu_grp_top`

## Requirements
- R1: While rst_n is low, at each rising clock edge result_o is set to 0, carry_o to 0 and zero_o to 1.
- R2: The result and flags of the inputs sampled at one rising edge are visible after that edge and stay until the next edge. func_i[4:3] selects the group: 0 logic, 1 arithmetic, 2 shift, 3 move. func_i[2:0] selects the operation within the group.
- R3: Logic group codes 0 to 7 give, in order: a&b, a|b, a^b, a&~b, a|~b, ~(a^b), ~(a&b), ~(a|b).
- R4: Arithmetic codes 0, 2 and 4 give a+b+k with k = 0, 1 and 2. carry_o is 1 when the unsigned sum exceeds 16 bits.
- R5: Arithmetic codes 1, 3 and 5 give a-b-k with k = 0, 1 and 2, wrapped to 16 bits. carry_o is 1 when b+k is greater than a as unsigned numbers (a borrow).
- R6: Arithmetic code 6 returns the smaller and code 7 the larger of a and b, both compared as signed 16-bit values.
- R7: Shift codes 0, 1 and 4 give a logical right shift, a logical left shift and an arithmetic right shift of a. The shift amount is b[3:0].
- R8: Shift codes 2 and 3 rotate a right and left by b[3:0], wrapping modulo 16. An amount of 0 returns a unchanged.
- R9: Shift code 5 gives the low byte and code 6 the high byte of the unsigned product a[7:0]*b[7:0], zero-extended. Code 7 (multiply initialise) returns b[7:0] zero-extended.
- R10: Move codes 0 to 3 give b, {a[15:8],b[7:0]}, b[7:0] sign-extended and b[7:0] zero-extended. Codes 4 to 7 behave as code 0.
- R11: carry_o is 0 for every function other than arithmetic codes 0 to 5.
- R12: zero_o is 1 exactly when result_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| func_i | input | 5 | Group (bits 4:3) and operation (bits 2:0) |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand, shift amount or byte source |
| result_o | output | 16 | Registered result |
| carry_o | output | 1 | Registered carry or borrow |
| zero_o | output | 1 | Registered all-zero flag |

## Verification
The assertions assume that func_i, a_i and b_i hold known values at every rising edge once reset is released. They compare each registered output against the inputs sampled one edge earlier, and they do so only after a full clock out of reset. The bench meets this by giving every input a defined value before the first edge and by changing the inputs only on falling edges. The directed vectors aim at carry and borrow limits, signed overflow in the compares, shift amounts of 0 and 15, and the move codes that are not otherwise used. After them, a pseudo-random sweep covers all 32 codes.

// File: rtl/alu_grp_pkg.sv
// Shared types for the grouped ALU: group selector encoding and code widths.
package alu_grp_pkg;
    localparam int FUNC_W = 5;
    localparam int OP_W   = 3;

    typedef enum logic [1:0] {
        GRP_LOGIC = 2'd0,
        GRP_ARITH = 2'd1,
        GRP_SHIFT = 2'd2,
        GRP_MOVE  = 2'd3
    } grp_e;
endpackage

// File: rtl/alu_grp_logic.sv
// Bitwise logic group: eight two-input functions selected by sel.
// Assumes sel is a known 3-bit code; purely combinational.
module alu_grp_logic #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   sel,
    output logic [W-1:0] y
);
    // Pick the logic function for the selected code.
    always_comb begin
        case (sel)
            3'd0:    y = a & b;
            3'd1:    y = a | b;
            3'd2:    y = a ^ b;
            3'd3:    y = a & ~b;
            3'd4:    y = a | ~b;
            3'd5:    y = ~(a ^ b);
            3'd6:    y = ~(a & b);
            default: y = ~(a | b);
        endcase
    end
endmodule

// File: rtl/alu_grp_arith.sv
// Arithmetic group: add and subtract with an extra constant of 0, 1 or 2,
// plus signed min/max. sel[0] picks subtract, sel[2:1] gives the constant;
// sel[2:1]==3 picks the compare operations. Combinational.
module alu_grp_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   sel,
    output logic [W-1:0] y,
    output logic         carry
);
    localparam int EW = W + 2;

    logic [1:0]    k;
    logic [EW-1:0] sum_ext;
    logic [EW-1:0] sub_rhs;
    logic [W-1:0]  diff;
    logic          a_lt_b;

    // Form the wide sum, the wide subtrahend and the signed comparison.
    always_comb begin
        k       = sel[2:1];
        sum_ext = {2'b00, a} + {2'b00, b} + EW'(k);
        sub_rhs = {2'b00, b} + EW'(k);
        diff    = a - b - W'(k);
        a_lt_b  = $signed(a) < $signed(b);
    end

    // Select the result and the carry or borrow for the operation.
    always_comb begin
        y     = '0;
        carry = 1'b0;
        if (k == 2'd3) begin
            y = (sel[0] ^ a_lt_b) ? a : b;
        end else if (sel[0]) begin
            y     = diff;
            carry = sub_rhs > {2'b00, a};
        end else begin
            y     = sum_ext[W-1:0];
            carry = |sum_ext[EW-1:W];
        end
    end
endmodule

// File: rtl/alu_grp_shift.sv
// Shift group: logical and arithmetic shifts, rotates, and the 8x8 multiply
// helpers. Takes only the low half of b: the shift amount and multiplier byte.
// Combinational.
module alu_grp_shift #(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W/2-1:0] b_lo,
    input  logic [2:0]     sel,
    output logic [W-1:0]   y
);
    localparam int H   = W / 2;
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] amt;
    logic [SHW-1:0] inv;
    logic [W-1:0]   prod;

    // Work out the shift amount, its complement modulo W, and the byte product.
    always_comb begin
        amt  = b_lo[SHW-1:0];
        inv  = SHW'(0) - amt;
        prod = W'(a[H-1:0]) * W'(b_lo);
    end

    // Select the shift, rotate or multiply helper output.
    always_comb begin
        case (sel)
            3'd0:    y = a >> amt;
            3'd1:    y = a << amt;
            3'd2:    y = (a >> amt) | (a << inv);
            3'd3:    y = (a << amt) | (a >> inv);
            3'd4:    y = W'($signed(a) >>> amt);
            3'd5:    y = {{H{1'b0}}, prod[H-1:0]};
            3'd6:    y = {{H{1'b0}}, prod[W-1:H]};
            default: y = {{H{1'b0}}, b_lo};
        endcase
    end
endmodule

// File: rtl/alu_grp_move.sv
// Move group: copy b, merge b's low byte under a's high byte, and extend
// b's low byte with sign or zero. Codes 4 to 7 act as a plain move. Combinational.
module alu_grp_move #(
    parameter int W = 16
) (
    input  logic [W/2-1:0] a_hi,
    input  logic [W-1:0]   b,
    input  logic [2:0]     sel,
    output logic [W-1:0]   y
);
    localparam int H = W / 2;

    // Select the move or byte operation.
    always_comb begin
        case (sel)
            3'd1:    y = {a_hi, b[H-1:0]};
            3'd2:    y = {{H{b[H-1]}}, b[H-1:0]};
            3'd3:    y = {{H{1'b0}}, b[H-1:0]};
            default: y = b;
        endcase
    end
endmodule

// File: rtl/alu_grp_top.sv
// Grouped ALU top: decodes the group field, muxes the four group units and
// registers result, carry and zero. Synchronous active-low reset.
// Assumes the inputs are stable around each rising edge.
module alu_grp_top
    import alu_grp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FUNC_W-1:0] func_i,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    output logic [W-1:0]      result_o,
    output logic              carry_o,
    output logic              zero_o
);
    localparam int H = W / 2;

    grp_e         grp;
    logic [OP_W-1:0] op;
    logic [W-1:0] y_logic, y_arith, y_shift, y_move;
    logic         c_arith;
    logic [W-1:0] y_next;
    logic         c_next;

    // Split the function code into group and operation fields.
    always_comb begin
        grp = grp_e'(func_i[FUNC_W-1:OP_W]);
        op  = func_i[OP_W-1:0];
    end

    alu_grp_logic #(.W(W)) logic_u (.a(a_i), .b(b_i), .sel(op), .y(y_logic));
    alu_grp_arith #(.W(W)) arith_u (.a(a_i), .b(b_i), .sel(op), .y(y_arith), .carry(c_arith));
    alu_grp_shift #(.W(W)) shift_u (.a(a_i), .b_lo(b_i[H-1:0]), .sel(op), .y(y_shift));
    alu_grp_move  #(.W(W)) move_u  (.a_hi(a_i[W-1:H]), .b(b_i), .sel(op), .y(y_move));

    // Route the selected group's result, and its carry only for arithmetic.
    always_comb begin
        c_next = 1'b0;
        case (grp)
            GRP_LOGIC: y_next = y_logic;
            GRP_ARITH: begin
                y_next = y_arith;
                c_next = c_arith;
            end
            GRP_SHIFT: y_next = y_shift;
            default:   y_next = y_move;
        endcase
    end

    // Register the result and the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            carry_o  <= 1'b0;
            zero_o   <= 1'b1;
        end else begin
            result_o <= y_next;
            carry_o  <= c_next;
            zero_o   <= (y_next == '0);
        end
    end
endmodule

// File: rtl/alu_grp_chk.sv
// Checker for the grouped ALU: relates the registered outputs to the inputs
// sampled one edge earlier. Assumes the inputs are known at each edge after reset.
module alu_grp_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [4:0]   func_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [W-1:0] result_o,
    input logic         carry_o,
    input logic         zero_o
);
    logic armed_q;

    // Mark the cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) armed_q <= rst_n;

    p_reset_vals_r1: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && !carry_o && zero_o));

    p_zero_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o == (result_o == '0));

    p_carry_scope_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ($past(func_i[4:3]) != 2'd1 || $past(func_i[2:1]) == 2'd3)) |-> !carry_o);

    p_logic_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(func_i) == 5'b00000) |-> result_o == ($past(a_i) & $past(b_i)));

    p_min_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(func_i) == 5'b01110) |->
        ($signed(result_o) <= $signed($past(a_i)) && $signed(result_o) <= $signed($past(b_i))));

    p_rot_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(func_i) == 5'b10010 && $past(b_i[3:0]) == 4'd0) |-> result_o == $past(a_i));

    p_mul_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(func_i[4:3]) == 2'd2 && $past(func_i[2:0]) >= 3'd5) |-> result_o[W-1:W/2] == '0);
endmodule

bind alu_grp_top alu_grp_chk #(.W(W)) chk_i (.*);

// File: tb/alu_grp_top_tb_top.sv
`timescale 1ns/1ps
module alu_grp_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  func_i = 5'd0;
    logic [15:0] a_i = 16'd0;
    logic [15:0] b_i = 16'd0;
    logic [15:0] result_o;
    logic        carry_o;
    logic        zero_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [4:0]  f;
        logic [15:0] res;
        logic        c;
    } exp_t;

    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    alu_grp_top dut_i (
        .clk(clk), .rst_n(rst_n), .func_i(func_i), .a_i(a_i), .b_i(b_i),
        .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o)
    );

    // Reference model written from the requirements: returns {carry, result}.
    function automatic logic [16:0] model(logic [4:0] f, logic [15:0] a, logic [15:0] b);
        int k;
        int s;
        logic [15:0] r;
        logic c;
        logic [15:0] p;
        r = 16'd0;
        c = 1'b0;
        k = int'(f[2:1]);
        case (f[4:3])
            2'd0: case (f[2:0])
                3'd0: r = a & b;
                3'd1: r = a | b;
                3'd2: r = a ^ b;
                3'd3: r = a & ~b;
                3'd4: r = a | ~b;
                3'd5: r = ~(a ^ b);
                3'd6: r = ~(a & b);
                default: r = ~(a | b);
            endcase
            2'd1: begin
                if (f[2:0] == 3'd6) r = ($signed(a) < $signed(b)) ? a : b;
                else if (f[2:0] == 3'd7) r = ($signed(a) > $signed(b)) ? a : b;
                else if (f[0]) begin
                    s = int'(a) - int'(b) - k;
                    r = s[15:0];
                    c = (s < 0);
                end else begin
                    s = int'(a) + int'(b) + k;
                    r = s[15:0];
                    c = (s > 65535);
                end
            end
            2'd2: begin
                p = 16'(a[7:0]) * 16'(b[7:0]);
                case (f[2:0])
                    3'd0: r = a >> b[3:0];
                    3'd1: r = a << b[3:0];
                    3'd2: begin
                        r = a;
                        for (int i = 0; i < int'(b[3:0]); i++) r = {r[0], r[15:1]};
                    end
                    3'd3: begin
                        r = a;
                        for (int i = 0; i < int'(b[3:0]); i++) r = {r[14:0], r[15]};
                    end
                    3'd4: begin
                        r = a;
                        for (int i = 0; i < int'(b[3:0]); i++) r = {r[15], r[15:1]};
                    end
                    3'd5: r = {8'h00, p[7:0]};
                    3'd6: r = {8'h00, p[15:8]};
                    default: r = {8'h00, b[7:0]};
                endcase
            end
            default: case (f[2:0])
                3'd1: r = {a[15:8], b[7:0]};
                3'd2: r = {{8{b[7]}}, b[7:0]};
                3'd3: r = {8'h00, b[7:0]};
                default: r = b;
            endcase
        endcase
        return {c, r};
    endfunction

    // Driver: apply one vector on a falling edge and queue its expected outputs.
    task automatic drive(string tag, logic [4:0] f, logic [15:0] a, logic [15:0] b);
        exp_t e;
        logic [16:0] m;
        @(negedge clk);
        func_i = f;
        a_i = a;
        b_i = b;
        m = model(f, a, b);
        e.tag = tag;
        e.f = f;
        e.res = m[15:0];
        e.c = m[16];
        sb_q.push_back(e);
    endtask

    // Monitor: after each edge, compare the registered outputs with the oldest expectation.
    always @(posedge clk) begin
        #1;
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            tests++;
            if (result_o !== e.res || carry_o !== e.c || zero_o !== (e.res == 16'd0)) begin
                fails++;
                $display("FAIL %s func=%b: got res=%h c=%b z=%b, expected res=%h c=%b z=%b",
                         e.tag, e.f, result_o, carry_o, zero_o, e.res, e.c, e.res == 16'd0);
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            summary();
        end
    end

    // Main stimulus sequence.
    initial begin
        logic [31:0] lfsr;
        // R1: nonzero inputs during reset must not reach the outputs.
        func_i = 5'b01000;
        a_i = 16'h1234;
        b_i = 16'h0001;
        repeat (3) @(posedge clk);
        #1;
        tests++;
        if (result_o !== 16'd0 || carry_o !== 1'b0 || zero_o !== 1'b1) begin
            fails++;
            $display("FAIL R1: got res=%h c=%b z=%b, expected res=0000 c=0 z=1", result_o, carry_o, zero_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R3 logic group, R2 group decode.
        for (int s = 0; s < 8; s++) drive("R3", 5'(s), 16'hF0CC, 16'hAA0F);
        drive("R2", 5'b00000, 16'h1234, 16'h4321);
        // R4 additions and carry limits.
        drive("R4", 5'b01000, 16'hFFFF, 16'h0001);
        drive("R4", 5'b01010, 16'hFFFE, 16'h0000);
        drive("R4", 5'b01100, 16'hFFFD, 16'h0000);
        drive("R4", 5'b01100, 16'h7FFF, 16'h7FFF);
        // R5 subtractions and borrow limits.
        drive("R5", 5'b01001, 16'h0005, 16'h0005);
        drive("R5", 5'b01011, 16'h0005, 16'h0005);
        drive("R5", 5'b01101, 16'h0006, 16'h0004);
        drive("R5", 5'b01101, 16'h0000, 16'hFFFF);
        // R6 signed compare, including sign boundaries.
        drive("R6", 5'b01110, 16'h8000, 16'h7FFF);
        drive("R6", 5'b01111, 16'h8000, 16'h7FFF);
        drive("R6", 5'b01110, 16'hFFFF, 16'h0001);
        drive("R6", 5'b01111, 16'h0003, 16'h0003);
        // R7 shifts with amounts 0, 15 and upper b bits ignored.
        drive("R7", 5'b10000, 16'h8001, 16'hFFF0);
        drive("R7", 5'b10001, 16'h8001, 16'h000F);
        drive("R7", 5'b10100, 16'h8000, 16'h000F);
        drive("R7", 5'b10100, 16'h4000, 16'h0003);
        // R8 rotates.
        drive("R8", 5'b10010, 16'h0001, 16'h0001);
        drive("R8", 5'b10011, 16'h8000, 16'h0001);
        drive("R8", 5'b10010, 16'hA5C3, 16'h0010);
        drive("R8", 5'b10011, 16'h1234, 16'h000F);
        // R9 multiply helpers.
        drive("R9", 5'b10101, 16'h33FF, 16'h44FF);
        drive("R9", 5'b10110, 16'h33FF, 16'h44FF);
        drive("R9", 5'b10111, 16'h1234, 16'h5680);
        drive("R9", 5'b10110, 16'h0010, 16'h0008);
        // R10 move group including codes 4..7.
        for (int s = 0; s < 8; s++) drive("R10", 5'(24 + s), 16'hBEEF, 16'h1280);
        // R11 no carry outside add/sub; R12 zero flag on a zero result.
        drive("R11", 5'b10001, 16'hFFFF, 16'h0001);
        drive("R11", 5'b00001, 16'hFFFF, 16'hFFFF);
        drive("R12", 5'b00010, 16'h5A5A, 16'h5A5A);
        drive("R12", 5'b11011, 16'hFFFF, 16'hFF00);

        // R2: pseudo-random sweep over all 32 codes.
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 600; n++) begin
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            drive("R2", 5'(n % 32), lfsr[31:16], lfsr[15:0] ^ lfsr[27:12]);
        end

        @(posedge clk);
        #2;
        done = 1'b1;
        summary();
    end
endmodule